// File: doc/BRIEF.md
# Bus DMA Address Translator

This block turns a 32-bit bus-side DMA address into a 48-bit system-link address. It also returns a target ID and attribute bits for the transfer. The incoming address picks one of three regions by range:

- **Local** addresses are passed through untranslated and flagged as local.
- **Mapped** addresses are looked up, 4 KB page by page, in an on-chip table of 128 entries of 64 bits each.
- **Direct** addresses are relocated as a whole 2 GB segment, using a segment number and target ID held in a relocation register.

The table and the relocation register are loaded through two plain write ports. Translations travel on a valid/ready stream:

- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- The result is registered and appears with `rsp_valid` one cycle later.
- A response holds all its fields steady until the downstream side raises `rsp_ready`.
- `req_ready` is high exactly when the response register is empty or is being drained in the same cycle. A stalled consumer therefore stops new requests without losing any.

Top module: `dma_xlat`

## Requirements
- R1: Requests below 0x4000_0000 return `rsp_local`=1, `rsp_fault`=0, the input address zero-extended, and zero target, attributes and rmf.
- R2: A request in 0x4000_0000..0x7FFF_FFFF uses table index = address bits 29:12. For a valid entry it returns:
  - address = {entry[47:12], request[11:0]}
  - `rsp_tid` = entry[11:8]
  - `rsp_attr` = entry[4:1], i.e. {barrier, prefetch, precise, coherent}
  - `rsp_rmf` = entry[63:48]
- R3: Whenever no fault is raised, response address bits 11:0 equal request address bits 11:0.
- R4: A mapped request whose index is 128 or more returns `rsp_fault`=1, and address, target, attributes and rmf all zero.
- R5: A mapped request hitting an entry whose bit 0 (valid) is clear returns `rsp_fault`=1 with all other fields zero.
- R6: A request at or above 0x8000_0000 returns:
  - address = segment × 2^31 + request[30:0], where the 17-bit segment sits at output bits 47:31
  - `rsp_tid` = the stored relocation target
  - no fault and no local flag
- R7: The response to an accepted request appears with `rsp_valid`=1 exactly one cycle after acceptance.
- R8: While `rsp_valid`=1 and `rsp_ready`=0, the response fields stay stable and `req_ready`=0. `req_ready` is high whenever `rsp_valid` is low.
- R9: A table write becomes visible to requests accepted in the following cycle. A request accepted on the same edge as the write sees the old entry.
- R10: After reset the following hold:
  - `rsp_valid`=0
  - every table entry is invalid
  - the relocation segment and target are zero

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Table entry write strobe |
| tbl_wr_idx | input | 7 | Table entry index |
| tbl_wr_data | input | 64 | Table entry contents |
| dmap_wr_en | input | 1 | Relocation register write strobe |
| dmap_wr_seg | input | 17 | Direct segment number |
| dmap_wr_tid | input | 4 | Direct target ID |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | 32 | Bus DMA address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Downstream takes response |
| rsp_addr | output | 48 | Translated address |
| rsp_tid | output | 4 | Target ID |
| rsp_attr | output | 4 | {barrier, prefetch, precise, coherent} |
| rsp_rmf | output | 16 | Read-modify field of entry |
| rsp_local | output | 1 | Local region, not translated |
| rsp_fault | output | 1 | Translation fault |

## Verification
The following are checked by assertions on every cycle:
- the one-cycle response latency;
- the response holding steady under back-pressure, and the ready rule;
- faulting responses carrying all-zero fields;
- page-offset passthrough;
- direct-window low-bit relocation.

Only the directed scenarios can show the rest:
- that table contents and relocation values land in the right output bit fields;
- that the index boundary at 127/128 falls where it should;
- that a write racing a request on the same edge is seen only by the next request.

// File: rtl/dma_xlat_pkg.sv
package dma_xlat_pkg;
  localparam int IN_W    = 32;
  localparam int OUT_W   = 48;
  localparam int PAGE_W  = 12;
  localparam int SEG_W   = 17;
  localparam int TID_W   = 4;
  localparam int RMF_W   = 16;
  localparam int FRAME_W = OUT_W - PAGE_W;

  typedef enum logic [1:0] {
    RGN_LOCAL  = 2'd0,
    RGN_MAPPED = 2'd1,
    RGN_DIRECT = 2'd2
  } region_e;

  typedef struct packed {
    logic [RMF_W-1:0]   rmf;
    logic [FRAME_W-1:0] frame;
    logic [TID_W-1:0]   tid;
    logic [2:0]         rsvd;
    logic               barrier;
    logic               prefetch;
    logic               precise;
    logic               coherent;
    logic               valid;
  } xlat_entry_t;
endpackage

// File: rtl/dma_xlat_table.sv
module dma_xlat_table #(
  parameter int ENTRIES = 128,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [63:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [63:0]      rd_data
);
  logic [63:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/dma_xlat_region.sv
module dma_xlat_region
  import dma_xlat_pkg::*;
#(
  parameter int ENTRIES = 128,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int WIN_HI = IN_W - 3
) (
  input  logic [IN_W-1:PAGE_W] addr_hi,
  output region_e              region,
  output logic [IDX_W-1:0]     idx,
  output logic                 idx_oob
);
  always_comb begin
    if (addr_hi[IN_W-1])        region = RGN_DIRECT;
    else if (addr_hi[IN_W-2])   region = RGN_MAPPED;
    else                        region = RGN_LOCAL;
  end

  assign idx = addr_hi[PAGE_W+IDX_W-1:PAGE_W];

  generate
    if (PAGE_W + IDX_W <= WIN_HI) begin : g_oob
      assign idx_oob = |addr_hi[WIN_HI:PAGE_W+IDX_W];
    end else begin : g_fit
      assign idx_oob = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dma_xlat.sv
module dma_xlat
  import dma_xlat_pkg::*;
#(
  parameter int ENTRIES = 128,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_wr_en,
  input  logic [IDX_W-1:0]  tbl_wr_idx,
  input  logic [63:0]       tbl_wr_data,
  input  logic              dmap_wr_en,
  input  logic [SEG_W-1:0]  dmap_wr_seg,
  input  logic [TID_W-1:0]  dmap_wr_tid,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IN_W-1:0]   req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [OUT_W-1:0]  rsp_addr,
  output logic [TID_W-1:0]  rsp_tid,
  output logic [3:0]        rsp_attr,
  output logic [RMF_W-1:0]  rsp_rmf,
  output logic              rsp_local,
  output logic              rsp_fault
);
  logic [SEG_W-1:0] seg_q;
  logic [TID_W-1:0] dtid_q;
  region_e          region;
  logic [IDX_W-1:0] idx;
  logic             idx_oob;
  logic [63:0]      ent_raw;
  xlat_entry_t      ent;
  logic             fire;

  logic [OUT_W-1:0] n_addr;
  logic [TID_W-1:0] n_tid;
  logic [3:0]       n_attr;
  logic [RMF_W-1:0] n_rmf;
  logic             n_local;
  logic             n_fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q  <= '0;
      dtid_q <= '0;
    end else if (dmap_wr_en) begin
      seg_q  <= dmap_wr_seg;
      dtid_q <= dmap_wr_tid;
    end
  end

  dma_xlat_table #(.ENTRIES(ENTRIES)) table_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_data(tbl_wr_data),
    .rd_idx(idx), .rd_data(ent_raw)
  );

  dma_xlat_region #(.ENTRIES(ENTRIES)) region_i (
    .addr_hi(req_addr[IN_W-1:PAGE_W]),
    .region(region), .idx(idx), .idx_oob(idx_oob)
  );

  assign ent = xlat_entry_t'(ent_raw);

  always_comb begin
    n_addr  = '0;
    n_tid   = '0;
    n_attr  = '0;
    n_rmf   = '0;
    n_local = 1'b0;
    n_fault = 1'b0;
    unique case (region)
      RGN_LOCAL: begin
        n_local = 1'b1;
        n_addr  = {{(OUT_W-IN_W){1'b0}}, req_addr};
      end
      RGN_MAPPED: begin
        if (idx_oob || !ent.valid) begin
          n_fault = 1'b1;
        end else begin
          n_addr = {ent.frame, req_addr[PAGE_W-1:0]};
          n_tid  = ent.tid;
          n_attr = {ent.barrier, ent.prefetch, ent.precise, ent.coherent};
          n_rmf  = ent.rmf;
        end
      end
      default: begin
        n_addr = {seg_q, req_addr[IN_W-2:0]};
        n_tid  = dtid_q;
      end
    endcase
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_tid   <= '0;
      rsp_attr  <= '0;
      rsp_rmf   <= '0;
      rsp_local <= 1'b0;
      rsp_fault <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_addr  <= n_addr;
      rsp_tid   <= n_tid;
      rsp_attr  <= n_attr;
      rsp_rmf   <= n_rmf;
      rsp_local <= n_local;
      rsp_fault <= n_fault;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_xlat_chk.sv
module dma_xlat_chk
  import dma_xlat_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [IN_W-1:0]  req_addr,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [OUT_W-1:0] rsp_addr,
  input logic [TID_W-1:0] rsp_tid,
  input logic [3:0]       rsp_attr,
  input logic [RMF_W-1:0] rsp_rmf,
  input logic             rsp_local,
  input logic             rsp_fault
);
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_tid)
      && $stable(rsp_attr) && $stable(rsp_rmf) && $stable(rsp_fault) && $stable(rsp_local));

  assert_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);

  // Covers both the out-of-range index case (R4) and the invalid-entry case (R5).
  assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_addr == '0 && rsp_tid == '0 && rsp_attr == '0
      && rsp_rmf == '0 && !rsp_local);

  assert_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_fault || rsp_addr[PAGE_W-1:0] == $past(req_addr[PAGE_W-1:0]));

  assert_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_addr[IN_W-1] |=>
      !rsp_fault && !rsp_local && rsp_addr[IN_W-2:0] == $past(req_addr[IN_W-2:0]));

  assert_local_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_addr[IN_W-1:IN_W-2] == 2'b00 |=>
      rsp_local && !rsp_fault);
endmodule

bind dma_xlat dma_xlat_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_addr(rsp_addr), .rsp_tid(rsp_tid), .rsp_attr(rsp_attr),
  .rsp_rmf(rsp_rmf), .rsp_local(rsp_local), .rsp_fault(rsp_fault)
);

// File: tb/dma_xlat_tb_top.sv
module dma_xlat_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_wr_en = 1'b0;
  logic [6:0]  tbl_wr_idx = '0;
  logic [63:0] tbl_wr_data = '0;
  logic        dmap_wr_en = 1'b0;
  logic [16:0] dmap_wr_seg = '0;
  logic [3:0]  dmap_wr_tid = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [47:0] rsp_addr;
  logic [3:0]  rsp_tid;
  logic [3:0]  rsp_attr;
  logic [15:0] rsp_rmf;
  logic        rsp_local;
  logic        rsp_fault;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_xlat dut_i (
    .clk(clk), .rst_n(rst_n),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data),
    .dmap_wr_en(dmap_wr_en), .dmap_wr_seg(dmap_wr_seg), .dmap_wr_tid(dmap_wr_tid),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_tid(rsp_tid), .rsp_attr(rsp_attr), .rsp_rmf(rsp_rmf),
    .rsp_local(rsp_local), .rsp_fault(rsp_fault)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_ent(input logic [35:0] frame, input logic [3:0] tid,
                                         input logic [3:0] attr, input logic v,
                                         input logic [15:0] rmf);
    return {rmf, frame, tid, 3'b000, attr, v};
  endfunction

  task automatic wr_ent(input logic [6:0] idx, input logic [63:0] d);
    tbl_wr_en = 1'b1; tbl_wr_idx = idx; tbl_wr_data = d;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  // Issue one request at a negedge; response is sampled at the next negedge.
  task automatic xlat(input logic [31:0] a);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 rsp_valid", {63'b0, rsp_valid}, 64'd0);
    chk("R8 req_ready idle", {63'b0, req_ready}, 64'd1);
    xlat(32'h4000_0000);
    chk("R10 entry0 invalid fault", {63'b0, rsp_fault}, 64'd1);
    xlat(32'h8000_0004);
    chk("R10 dmap zero addr", {16'b0, rsp_addr}, 64'h8000_0004 & 64'h7FFF_FFFF);
  endtask

  task automatic t_local;
    xlat(32'h1234_5678);
    chk("R7 rsp_valid", {63'b0, rsp_valid}, 64'd1);
    chk("R1 local flag", {63'b0, rsp_local}, 64'd1);
    chk("R1 local addr", {16'b0, rsp_addr}, 64'h1234_5678);
    xlat(32'h3FFF_FFFF);
    chk("R1 local top", {62'b0, rsp_local, rsp_fault}, 64'd2);
  endtask

  task automatic t_mapped;
    wr_ent(7'd5, mk_ent(36'h9_ABCD_E012, 4'h7, 4'b1010, 1'b1, 16'hBEEF));
    xlat(32'h4000_5ABC);
    chk("R2 addr", {16'b0, rsp_addr}, 64'h9ABC_DE01_2ABC);
    chk("R2 tid", {60'b0, rsp_tid}, 64'h7);
    chk("R2 attr", {60'b0, rsp_attr}, 64'hA);
    chk("R2 rmf", {48'b0, rsp_rmf}, 64'hBEEF);
    chk("R3 offset", {52'b0, rsp_addr[11:0]}, 64'hABC);
    wr_ent(7'd127, mk_ent(36'h0_0000_0042, 4'h3, 4'b0001, 1'b1, 16'h0001));
    xlat(32'h4007_F001);
    chk("R4 idx127 ok", {16'b0, rsp_addr}, 64'h42001);
  endtask

  task automatic t_faults;
    xlat(32'h4008_0000);
    chk("R4 idx128 fault", {63'b0, rsp_fault}, 64'd1);
    chk("R4 idx128 addr", {16'b0, rsp_addr}, 64'd0);
    xlat(32'h7FFF_FFFF);
    chk("R4 top fault", {63'b0, rsp_fault}, 64'd1);
    xlat(32'h4000_3123);
    chk("R5 invalid fault", {63'b0, rsp_fault}, 64'd1);
    chk("R5 invalid addr", {16'b0, rsp_addr}, 64'd0);
    wr_ent(7'd9, mk_ent(36'h1_1111_1111, 4'hF, 4'hF, 1'b0, 16'hFFFF));
    xlat(32'h4000_9000);
    chk("R5 cleared valid", {44'b0, rsp_tid, rsp_attr, rsp_rmf[7:0], rsp_fault}, 64'd1);
  endtask

  task automatic t_direct;
    dmap_wr_en = 1'b1; dmap_wr_seg = 17'h3; dmap_wr_tid = 4'hA;
    @(negedge clk);
    dmap_wr_en = 1'b0;
    xlat(32'h8000_0010);
    chk("R6 addr", {16'b0, rsp_addr}, 64'h1_8000_0010);
    chk("R6 tid", {60'b0, rsp_tid}, 64'hA);
    xlat(32'hFFFF_FFFF);
    chk("R6 top addr", {16'b0, rsp_addr}, 64'h1_FFFF_FFFF);
    chk("R6 flags", {62'b0, rsp_local, rsp_fault}, 64'd0);
  endtask

  task automatic t_race;
    tbl_wr_en = 1'b1; tbl_wr_idx = 7'd20;
    tbl_wr_data = mk_ent(36'h0_0000_0777, 4'h2, 4'h0, 1'b1, 16'h0);
    req_valid = 1'b1; req_addr = 32'h4001_4008;
    @(negedge clk);
    tbl_wr_en = 1'b0; req_valid = 1'b0;
    chk("R9 same-edge old", {63'b0, rsp_fault}, 64'd1);
    xlat(32'h4001_4008);
    chk("R9 next new", {16'b0, rsp_addr}, 64'h777008);
  endtask

  task automatic t_backpressure;
    logic [47:0] held;
    rsp_ready = 1'b0;
    xlat(32'h0000_0AAA);
    held = rsp_addr;
    repeat (3) @(negedge clk);
    chk("R8 held valid", {63'b0, rsp_valid}, 64'd1);
    chk("R8 held addr", {16'b0, rsp_addr}, {16'b0, held});
    chk("R8 not ready", {63'b0, req_ready}, 64'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R7 drained", {63'b0, rsp_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_local;
    t_mapped;
    t_faults;
    t_direct;
    t_race;
    t_backpressure;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule